// File: doc/BRIEF.md
# Round-Robin Unit Selector with Ready Tracking

This block manages the units of one execution resource. The resource is either a single resource with several identical units or a group built from member resources. It keeps a shrinking candidate mask and offers the highest-numbered candidate unit as the next pick. When the candidate set runs out, the mask refills from the configured unit set. This gives a fixed descending rotation over the units.

A caller can also claim a specific unit directly by passing its one-hot ID. That unit leaves the rotation. If the unit had already left the rotation in the current pass, it is remembered instead and left out of the next refill. Separately, the block keeps a per-unit ready mask that use and release requests toggle. From that mask it answers whether at least a requested number of units is free. The answer also takes into account a reserved flag, which a dispatch-hazard flag overrides.

Configuration comes from static inputs. A synchronous reset loads it. All requests are single-cycle strobes. Outputs are combinational from the current state and inputs, and the state moves on at the next rising clock edge.

Top module: `unit_rr_selector`

## Requirements
- R1: In group mode (`cfg_group`=1), the unit set is `cfg_res_mask` with its most significant set bit cleared, truncated to W bits. After reset both the candidate mask and `ready_mask` equal this set.
- R2: In unit-count mode (`cfg_group`=0), the unit set has bits 0 to `cfg_units`-1 set. All W bits are set when `cfg_units` is W or more. After reset both the candidate mask and `ready_mask` equal this set.
- R3: `pick_id` is one-hot, with bit i meaning unit i. It is the highest set bit of the current candidate mask, and it is zero when the candidate mask is empty.
- R4: A cycle with `sel_req`=1 clears the picked bit from the candidate mask at the next edge. If the mask would then be empty, it is refilled instead.
- R5: With `fix_req`=1, `sel_req`=0 and a one-hot `fix_id` whose bit is in the candidate mask, that bit is cleared at the next edge. A `fix_id` that is not one-hot is ignored, and `fix_req` has no effect in a cycle where `sel_req`=1.
- R6: A one-hot `fix_id` whose bit is not in the candidate mask is added to a removal record. A refill loads the unit set minus the removal record (including any bit added in that same cycle) and then clears the record. A refill happens only when a select or valid static claim leaves the mask empty.
- R7: A valid use (one-hot `use_id` whose bit is set in `ready_mask`) clears that bit at the next edge. A valid release (one-hot `rel_id` whose bit is in the unit set and clear in `ready_mask`) sets it. With no requests, `ready_mask` holds.
- R8: A use or release that is not valid drives `err` high in the same cycle and does not change `ready_mask`. A valid request in the same cycle still takes effect.
- R9: `units_ok` is 1 exactly when the popcount of `ready_mask` is at least `need_units` and either `reserved`=0 or `hazard`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads configuration |
| cfg_group | input | 1 | 1: group mode, 0: unit-count mode |
| cfg_res_mask | input | W+1 | Group mask: member bits plus a top group bit |
| cfg_units | input | CW | Unit count for unit-count mode |
| sel_req | input | 1 | Take the current pick and advance rotation |
| fix_req | input | 1 | Static claim of `fix_id` |
| fix_id | input | W | One-hot unit for static claim |
| use_req | input | 1 | Mark `use_id` busy |
| use_id | input | W | One-hot unit to mark busy |
| rel_req | input | 1 | Mark `rel_id` free |
| rel_id | input | W | One-hot unit to free |
| need_units | input | CW | Unit count asked of `units_ok` |
| reserved | input | 1 | Resource reserved |
| hazard | input | 1 | Resource is a dispatch hazard; overrides `reserved` |
| pick_id | output | W | One-hot next unit in rotation |
| ready_mask | output | W | Free units |
| units_ok | output | 1 | Enough free units and not blocked |
| err | output | 1 | Invalid use or release this cycle |

## Verification
The assertions take the configuration inputs as constant while reset is released. The unit set is only reloaded under reset, so a change outside reset would break the refill property. The bench therefore changes configuration only while `rst_n` is low. It drives requests at mid-cycle with random one-hot IDs, and mixes in occasional multi-bit or out-of-set IDs to hit the error and ignore paths. It also uses directed sequences for the collision of select with a static claim, for a claim of an already-cleared unit followed by a refill, and for the reserved and hazard combinations.

// File: rtl/urs_pkg.sv
package urs_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_SEL  = 2'd1,
    UPD_FIX  = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/urs_candidate.sv
module urs_candidate
  import urs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] size_mask,
  input  logic         sel_req,
  input  logic         fix_req,
  input  logic [W-1:0] fix_id,
  output logic [W-1:0] pick_id,
  output logic [W-1:0] cand_q,
  output logic [W-1:0] rem_q
);
  upd_kind_e    kind;
  logic [W-1:0] cand_n;
  logic [W-1:0] rem_n;

  always_comb begin
    pick_id = '0;
    for (int i = 0; i < W; i++) begin
      if (cand_q[i]) begin
        pick_id    = '0;
        pick_id[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (sel_req)                       kind = UPD_SEL;
    else if (fix_req && $onehot(fix_id)) kind = UPD_FIX;
    else                               kind = UPD_NONE;
  end

  always_comb begin
    cand_n = cand_q;
    rem_n  = rem_q;
    case (kind)
      UPD_SEL: cand_n = cand_q & ~pick_id;
      UPD_FIX: begin
        if ((cand_q & fix_id) != '0) cand_n = cand_q & ~fix_id;
        else                         rem_n  = rem_q | fix_id;
      end
      default: ;
    endcase
    if (kind != UPD_NONE && cand_n == '0) begin
      cand_n = size_mask & ~rem_n;
      rem_n  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_q <= size_mask;
      rem_q  <= '0;
    end else begin
      cand_q <= cand_n;
      rem_q  <= rem_n;
    end
  end
endmodule

// File: rtl/urs_ready.sv
module urs_ready #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  size_mask,
  input  logic          use_req,
  input  logic [W-1:0]  use_id,
  input  logic          rel_req,
  input  logic [W-1:0]  rel_id,
  input  logic [CW-1:0] need_units,
  input  logic          reserved,
  input  logic          hazard,
  output logic [W-1:0]  ready_q,
  output logic          units_ok,
  output logic          err
);
  logic          use_ok;
  logic          rel_ok;
  logic [CW-1:0] free_cnt;
  logic [W-1:0]  ready_n;

  assign use_ok = $onehot(use_id) && ((ready_q & use_id) != '0);
  assign rel_ok = $onehot(rel_id) && ((ready_q & rel_id) == '0) &&
                  ((size_mask & rel_id) != '0);
  assign err    = (use_req && !use_ok) || (rel_req && !rel_ok);

  always_comb begin
    ready_n = ready_q;
    if (use_req && use_ok) ready_n = ready_n & ~use_id;
    if (rel_req && rel_ok) ready_n = ready_n | rel_id;
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < W; i++) free_cnt = free_cnt + CW'(ready_q[i]);
  end

  assign units_ok = (!reserved || hazard) && (free_cnt >= need_units);

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= size_mask;
    else        ready_q <= ready_n;
  end
endmodule

// File: rtl/unit_rr_selector.sv
module unit_rr_selector #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_group,
  input  logic [W:0]    cfg_res_mask,
  input  logic [CW-1:0] cfg_units,
  input  logic          sel_req,
  input  logic          fix_req,
  input  logic [W-1:0]  fix_id,
  input  logic          use_req,
  input  logic [W-1:0]  use_id,
  input  logic          rel_req,
  input  logic [W-1:0]  rel_id,
  input  logic [CW-1:0] need_units,
  input  logic          reserved,
  input  logic          hazard,
  output logic [W-1:0]  pick_id,
  output logic [W-1:0]  ready_mask,
  output logic          units_ok,
  output logic          err
);
  logic [W-1:0] low_bits;
  logic [W-1:0] low_top;
  logic [W-1:0] grp_size;
  logic [W-1:0] cnt_size;
  logic [W-1:0] size_mask;
  logic [W-1:0] cand_q;
  logic [W-1:0] rem_q;

  assign low_bits = cfg_res_mask[W-1:0];

  always_comb begin
    low_top = '0;
    for (int i = 0; i < W; i++) begin
      if (low_bits[i]) begin
        low_top    = '0;
        low_top[i] = 1'b1;
      end
    end
  end

  // the group bit is the highest set bit; it lives above bit W-1 or inside low bits
  assign grp_size = cfg_res_mask[W] ? low_bits : (low_bits & ~low_top);

  for (genvar g = 0; g < W; g++) begin : g_cnt
    assign cnt_size[g] = (int'(cfg_units) > g);
  end

  assign size_mask = cfg_group ? grp_size : cnt_size;

  urs_candidate #(.W(W)) u_cand (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_mask (size_mask),
    .sel_req   (sel_req),
    .fix_req   (fix_req),
    .fix_id    (fix_id),
    .pick_id   (pick_id),
    .cand_q    (cand_q),
    .rem_q     (rem_q)
  );

  urs_ready #(.W(W), .CW(CW)) u_rdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .size_mask  (size_mask),
    .use_req    (use_req),
    .use_id     (use_id),
    .rel_req    (rel_req),
    .rel_id     (rel_id),
    .need_units (need_units),
    .reserved   (reserved),
    .hazard     (hazard),
    .ready_q    (ready_mask),
    .units_ok   (units_ok),
    .err        (err)
  );
endmodule

// File: rtl/urs_checker.sv
module urs_checker #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_req,
  input logic          use_req,
  input logic [W-1:0]  use_id,
  input logic          rel_req,
  input logic [W-1:0]  rel_id,
  input logic [CW-1:0] need_units,
  input logic          reserved,
  input logic          hazard,
  input logic [W-1:0]  pick_id,
  input logic [W-1:0]  ready_mask,
  input logic          units_ok,
  input logic          err,
  input logic [W-1:0]  size_mask,
  input logic [W-1:0]  cand_q,
  input logic [W-1:0]  rem_q
);
  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pick_id)); // R3
  AST_PICK_IN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    ((pick_id & ~cand_q) == '0) && ((cand_q == '0) || (pick_id != '0))); // R3
  AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && ((cand_q & ~pick_id) != '0)) |=> ((cand_q & $past(pick_id)) == '0)); // R4
  AST_REFILL_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && ((cand_q & ~pick_id) == '0)) |=> (cand_q == (size_mask & ~$past(rem_q)))); // R6
  AST_REFILL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && ((cand_q & ~pick_id) == '0)) |=> (rem_q == '0)); // R6
  AST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (use_req && $onehot(use_id) && ((ready_mask & use_id) != '0))
      |=> ((ready_mask & $past(use_id)) == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_req && !rel_req) |=> $stable(ready_mask)); // R7
  AST_BAD_USE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (use_req && ((ready_mask & use_id) == '0)) |-> err); // R8
  AST_BAD_USE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (use_req && !rel_req && ((ready_mask & use_id) == '0)) |=> $stable(ready_mask)); // R8
  AST_BAD_REL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && ((ready_mask & rel_id) != '0)) |-> err); // R8
  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reserved && !hazard) |-> !units_ok); // R9
  AST_OK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    units_ok |-> ($countones(ready_mask) >= int'(need_units))); // R9
endmodule

bind unit_rr_selector urs_checker #(.W(W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_req    (sel_req),
  .use_req    (use_req),
  .use_id     (use_id),
  .rel_req    (rel_req),
  .rel_id     (rel_id),
  .need_units (need_units),
  .reserved   (reserved),
  .hazard     (hazard),
  .pick_id    (pick_id),
  .ready_mask (ready_mask),
  .units_ok   (units_ok),
  .err        (err),
  .size_mask  (size_mask),
  .cand_q     (cand_q),
  .rem_q      (rem_q)
);

// File: tb/tb_unit_rr_selector.sv
module tb_unit_rr_selector;
  localparam int W          = 8;
  localparam int CW         = $clog2(W + 1);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_group = 1'b0;
  logic [W:0]    cfg_res_mask = '0;
  logic [CW-1:0] cfg_units = '0;
  logic          sel_req = 1'b0, fix_req = 1'b0, use_req = 1'b0, rel_req = 1'b0;
  logic [W-1:0]  fix_id = '0, use_id = '0, rel_id = '0;
  logic [CW-1:0] need_units = '0;
  logic          reserved = 1'b0, hazard = 1'b0;
  logic [W-1:0]  pick_id, ready_mask;
  logic          units_ok, err;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_size, m_cand, m_rem, m_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  unit_rr_selector #(.W(W), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_group(cfg_group), .cfg_res_mask(cfg_res_mask),
    .cfg_units(cfg_units), .sel_req(sel_req), .fix_req(fix_req), .fix_id(fix_id),
    .use_req(use_req), .use_id(use_id), .rel_req(rel_req), .rel_id(rel_id),
    .need_units(need_units), .reserved(reserved), .hazard(hazard),
    .pick_id(pick_id), .ready_mask(ready_mask), .units_ok(units_ok), .err(err)
  );

  function automatic logic [W-1:0] top_of(input logic [W-1:0] m);
    logic [W-1:0] r = '0;
    for (int i = W - 1; i >= 0; i--) if (m[i] && r == '0) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [W-1:0] spec_size(input logic grp, input logic [W:0] rm,
                                             input logic [CW-1:0] nu);
    logic [W-1:0] s = '0;
    if (grp) begin
      logic [W:0] t = '0;
      for (int i = W; i >= 0; i--) if (rm[i] && t == '0) t[i] = 1'b1;
      s = W'(rm & ~t);
    end else begin
      for (int i = 0; i < W; i++) s[i] = (i < int'(nu));
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic do_reset(input logic grp, input logic [W:0] rm, input logic [CW-1:0] nu);
    @(negedge clk);
    rst_n = 1'b0; cfg_group = grp; cfg_res_mask = rm; cfg_units = nu;
    sel_req = 0; fix_req = 0; use_req = 0; rel_req = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_size = spec_size(grp, rm, nu);
    m_cand = m_size; m_rem = '0; m_rdy = m_size;
  endtask

  // compare all outputs against the spec model, then advance the model by one edge
  task automatic cyc(input string ptag, input string rtag);
    logic bu, br, act;
    logic [W-1:0] c, r, nr;
    int cnt;
    #1;
    bu = use_req && !($onehot(use_id) && (m_rdy & use_id) != '0);
    br = rel_req && !($onehot(rel_id) && (m_rdy & rel_id) == '0 && (m_size & rel_id) != '0);
    cnt = $countones(m_rdy);
    chk(ptag, 32'(pick_id), 32'(top_of(m_cand)));
    chk(rtag, 32'(ready_mask), 32'(m_rdy));
    chk("R8 err", 32'(err), 32'(bu || br));
    chk("R9 units_ok", 32'(units_ok), 32'((!reserved || hazard) && cnt >= int'(need_units)));
    c = m_cand; r = m_rem; act = 1'b0;
    if (sel_req) begin c = m_cand & ~top_of(m_cand); act = 1'b1; end
    else if (fix_req && $onehot(fix_id)) begin
      act = 1'b1;
      if ((m_cand & fix_id) != '0) c = m_cand & ~fix_id; else r = m_rem | fix_id;
    end
    if (act && c == '0) begin c = m_size & ~r; r = '0; end
    nr = m_rdy;
    if (use_req && !bu) nr = nr & ~use_id;
    if (rel_req && !br) nr = nr | rel_id;
    m_cand = c; m_rem = r; m_rdy = nr;
    @(negedge clk);
  endtask

  task automatic idle();
    sel_req = 0; fix_req = 0; use_req = 0; rel_req = 0; fix_id = '0; use_id = '0; rel_id = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    // group: members 6,5,3,1 and top group bit 8
    do_reset(1'b1, 9'h16A, '0);
    #1;
    chk("R1 reset ready", 32'(ready_mask), 32'h6A);
    chk("R3 reset pick", 32'(pick_id), 32'h40);
    idle(); sel_req = 1; cyc("R3", "R7");
    chk("R4 after one select", 32'(pick_id), 32'h20);
    cyc("R4", "R7");
    fix_req = 1; fix_id = 8'h08; cyc("R5", "R7");           // select wins over fix
    idle();
    chk("R5 select beat fix", 32'(pick_id), 32'h02);
    fix_req = 1; fix_id = 8'h40; cyc("R6", "R7");           // already cleared -> recorded
    fix_id = 8'h02; cyc("R5", "R7");                       // empties -> refill minus 0x40
    idle();
    chk("R6 refill stripped", 32'(pick_id), 32'h20);
    fix_req = 1; fix_id = 8'h30; cyc("R5", "R7");           // not one-hot: ignored
    idle();
    chk("R5 multi-bit fix ignored", 32'(pick_id), 32'h20);
    sel_req = 1; cyc("R4", "R7"); cyc("R4", "R7"); cyc("R4", "R7");
    idle();
    chk("R6 record cleared after refill", 32'(pick_id), 32'h40);
    // ready tracking
    use_req = 1; use_id = 8'h40; cyc("R3", "R7");
    chk("R7 use clears", 32'(ready_mask), 32'h2A);
    cyc("R3", "R8");
    chk("R8 double use held", 32'(ready_mask), 32'h2A);
    idle(); rel_req = 1; rel_id = 8'h01; cyc("R3", "R8");
    chk("R8 release outside set held", 32'(ready_mask), 32'h2A);
    idle(); use_req = 1; use_id = 8'h22; cyc("R3", "R8");
    idle(); rel_req = 1; rel_id = 8'h40; cyc("R3", "R7");
    idle();
    chk("R7 release sets", 32'(ready_mask), 32'h6A);
    need_units = 4; cyc("R3", "R7");
    need_units = 5; cyc("R3", "R7");
    need_units = 1; reserved = 1; cyc("R3", "R7");
    hazard = 1; #1;
    chk("R9 hazard overrides reserved", 32'(units_ok), 32'h1);
    cyc("R3", "R7");
    reserved = 0; hazard = 0;
    // unit-count mode
    do_reset(1'b0, '0, 4'd5);
    #1;
    chk("R2 reset ready five units", 32'(ready_mask), 32'h1F);
    chk("R2 reset pick", 32'(pick_id), 32'h10);
    do_reset(1'b0, '0, 4'd12);
    #1;
    chk("R2 count above width", 32'(ready_mask), 32'hFF);
    // random phases
    for (int ph = 0; ph < 3; ph++) begin
      if (ph == 0) do_reset(1'b1, 9'h00B, '0);
      else if (ph == 1) do_reset(1'b0, '0, 4'd6);
      else do_reset(1'b1, 9'h1F7, '0);
      for (int k = 0; k < 2500; k++) begin
        sel_req = ($urandom % 3) == 0;
        fix_req = ($urandom % 4) == 0;
        fix_id = ($urandom % 10 == 0) ? W'($urandom) : W'(1) << ($urandom % W);
        use_req = ($urandom % 3) == 0;
        use_id = ($urandom % 8 == 0) ? W'($urandom) : W'(1) << ($urandom % W);
        rel_req = ($urandom % 3) == 0;
        rel_id = ($urandom % 8 == 0) ? W'($urandom) : W'(1) << ($urandom % W);
        need_units = CW'($urandom % 10);
        reserved = ($urandom % 4) == 0;
        hazard = ($urandom % 2) == 0;
        cyc("R3 random pick", "R7 random ready");
      end
    end
    summary();
    $finish;
  end
endmodule